// File: doc/BRIEF.md
# Packed SIMD Saturating ALU

This block is a 64-bit packed arithmetic unit. Each operand word is split at run time into eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. Every lane is computed on its own, and no carry or borrow crosses a lane boundary. Addition and subtraction can wrap modulo the lane width, clamp to the signed two's-complement range, or clamp to the unsigned range. Two multiply forms work on 16-bit lanes: one keeps the low half of each 32-bit product and the other keeps the high half. A pairwise multiply-accumulate multiplies neighbouring 16-bit lanes and adds each pair of products into one 32-bit result lane.

A caller presents both operands with an opcode, a lane-size code and a saturation code, and pulses `in_valid` for one cycle. The answer is registered and appears with `out_valid` on the next clock edge. A combination that the unit does not support returns zero and raises `illegal`.

A two-state controller (`S_IDLE`, `S_DONE`) produces `out_valid`. It has two transitions. **CAPTURE** goes to `S_DONE` on any cycle where `in_valid` is high, from either state. **RELEASE** goes back to `S_IDLE` on any cycle where `in_valid` is low. The controller therefore stays in `S_DONE` for as long as strobes arrive back to back.

Top module: `simd_sat_alu`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low after each cycle in which `in_valid` is low. `result` and `illegal` are updated in that same cycle.
- R2: While `rst_n` is low and afterwards until the first strobe, `out_valid`, `illegal` and `result` are all zero.
- R3: `lane_sel` selects the lane width: 0 for 8 bits, 1 for 16, 2 for 32 and 3 for 64. `opcode` 0 is add and 1 is subtract (a minus b). With `sat_mode` 0 each lane wraps modulo 2^width, and carries are cut at lane boundaries.
- R4: With `sat_mode` 1, an add or subtract that overflows a lane's signed range returns the lane maximum (0x7F..F) when the true value is positive and the lane minimum (0x80..0) when it is negative.
- R5: With `sat_mode` 2, an unsigned add that overflows returns all ones, and an unsigned subtract that goes below zero returns zero.
- R6: `opcode` 2 multiplies 16-bit lanes and returns the low 16 bits of each product. `opcode` 3 returns the high 16 bits: the product is unsigned when `sat_mode` is 2 and signed otherwise.
- R7: `opcode` 4 with 16-bit lanes returns, for 32-bit result lane j, a[2j]*b[2j] + a[2j+1]*b[2j+1]. With `sat_mode` 0 the products are signed and the sum wraps. With 1 the products are signed and the sum clamps to the signed 32-bit range. With 2 the products are unsigned and the sum clamps to 0xFFFFFFFF.
- R8: An opcode above 4, a `sat_mode` of 3, or `opcode` 2, 3 or 4 with a lane size other than 16 bits gives a zero `result` with `illegal` high. The next legal operation clears `illegal`.
- R9: Between strobes, `result` and `illegal` keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op_a | input | 64 | First packed operand |
| op_b | input | 64 | Second packed operand |
| opcode | input | 3 | 0 add, 1 subtract, 2 multiply low, 3 multiply high, 4 pairwise multiply-accumulate |
| lane_sel | input | 2 | Lane width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| sat_mode | input | 2 | 0 wrap, 1 signed clamp, 2 unsigned clamp, 3 reserved |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| result | output | 64 | Packed result |
| illegal | output | 1 | Unsupported combination was requested |

## Verification
Every result is due exactly one rising edge after its strobe, because the arithmetic is combinational in front of a single output register. The bench drives each strobe on a falling edge, lowers it on the next falling edge, and reads `result`, `illegal` and `out_valid` at that moment, half a period after the capturing edge. One falling edge later it reads again, expecting `out_valid` low and the data unchanged. This shows both that the strobe lasts a single cycle and that the data holds between strobes.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
    localparam int WORD_W    = 64;
    localparam int NUM_SIZES = 4;
    localparam int MUL_W     = 16;
    localparam int OP_W      = 3;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_MULLO = 3'd2,
        OP_MULHI = 3'd3,
        OP_MAC   = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        LN_8  = 2'd0,
        LN_16 = 2'd1,
        LN_32 = 2'd2,
        LN_64 = 2'd3
    } lane_e;

    typedef enum logic [1:0] {
        SAT_WRAP     = 2'd0,
        SAT_SIGNED   = 2'd1,
        SAT_UNSIGNED = 2'd2,
        SAT_RSVD     = 2'd3
    } sat_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_DONE = 1'b1
    } st_e;
endpackage

// File: rtl/simd_addsub.sv
module simd_addsub
    import simd_alu_pkg::*;
#(
    parameter int DW = WORD_W
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    input  lane_e         lane,
    input  sat_e          sat,
    output logic [DW-1:0] y
);
    localparam int NSZ = NUM_SIZES;

    logic [DW-1:0] cand [NSZ];

    for (genvar w = 0; w < NSZ; w++) begin : g_size
        localparam int LW = 8 << w;
        localparam int NL = DW / LW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            logic [LW-1:0] la, lb, r;
            logic [LW:0]   us, ss;
            assign la = a[l*LW +: LW];
            assign lb = b[l*LW +: LW];
            always_comb begin
                us = sub ? ({1'b0, la} - {1'b0, lb}) : ({1'b0, la} + {1'b0, lb});
                ss = sub ? ({la[LW-1], la} - {lb[LW-1], lb})
                         : ({la[LW-1], la} + {lb[LW-1], lb});
                r = us[LW-1:0];
                if (sat == SAT_SIGNED && (ss[LW] != ss[LW-1])) begin
                    r = ss[LW] ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
                end else if (sat == SAT_UNSIGNED && us[LW]) begin
                    r = sub ? '0 : '1;
                end
            end
            // R5: an unsigned clamped sum never drops below its first addend
            always_comb begin
                if (sat == SAT_UNSIGNED && !sub && lane == lane_e'(w)) begin
                    assert_usat_floor_R5: assert (r >= la)
                        else $error("unsigned clamped sum below addend");
                end
            end
            assign cand[w][l*LW +: LW] = r;
        end
    end

    assign y = cand[lane];
endmodule

// File: rtl/simd_mul16.sv
module simd_mul16
    import simd_alu_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int LW = MUL_W
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          hi,
    input  logic          mac,
    input  sat_e          sat,
    output logic [DW-1:0] y
);
    localparam int NL = DW / LW;
    localparam int PW = 2 * LW;
    localparam int NP = NL / 2;

    logic [PW-1:0] ps [NL];
    logic [PW-1:0] pu [NL];
    logic [DW-1:0] y_mul, y_mac;

    for (genvar l = 0; l < NL; l++) begin : g_prod
        logic [PW-1:0] pp;
        assign ps[l] = $signed(a[l*LW +: LW]) * $signed(b[l*LW +: LW]);
        assign pu[l] = {{LW{1'b0}}, a[l*LW +: LW]} * {{LW{1'b0}}, b[l*LW +: LW]};
        assign pp    = (hi && sat == SAT_UNSIGNED) ? pu[l] : ps[l];
        assign y_mul[l*LW +: LW] = hi ? pp[PW-1:LW] : pp[LW-1:0];
    end

    for (genvar j = 0; j < NP; j++) begin : g_pair
        logic [PW:0]   ssum, usum;
        logic [PW-1:0] r;
        assign ssum = {ps[2*j][PW-1], ps[2*j]} + {ps[2*j+1][PW-1], ps[2*j+1]};
        assign usum = {1'b0, pu[2*j]} + {1'b0, pu[2*j+1]};
        always_comb begin
            unique case (sat)
                SAT_SIGNED: begin
                    if (ssum[PW] != ssum[PW-1])
                        r = ssum[PW] ? {1'b1, {(PW-1){1'b0}}} : {1'b0, {(PW-1){1'b1}}};
                    else
                        r = ssum[PW-1:0];
                end
                SAT_UNSIGNED: r = usum[PW] ? '1 : usum[PW-1:0];
                default:      r = ssum[PW-1:0];
            endcase
        end
        // R7: an unsigned clamped pair sum is never below either product
        always_comb begin
            if (sat == SAT_UNSIGNED) begin
                assert_umac_floor_R7: assert (r >= pu[2*j] && r >= pu[2*j+1])
                    else $error("unsigned pair sum below a product");
            end
        end
        assign y_mac[j*PW +: PW] = r;
    end

    assign y = mac ? y_mac : y_mul;
endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
    import simd_alu_pkg::*;
#(
    parameter int DW = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic [2:0]    opcode,
    input  logic [1:0]    lane_sel,
    input  logic [1:0]    sat_mode,
    output logic          out_valid,
    output logic [DW-1:0] result,
    output logic          illegal
);
    st_e           state, state_nx;
    op_e           op;
    lane_e         lane;
    sat_e          sat;
    logic [DW-1:0] y_as, y_mul, res_nx;
    logic          bad;
    logic [DW-1:0] res_q;
    logic          ill_q;

    assign op   = op_e'(opcode);
    assign lane = lane_e'(lane_sel);
    assign sat  = sat_e'(sat_mode);

    simd_addsub #(.DW(DW)) u_addsub (
        .a(op_a), .b(op_b), .sub(op == OP_SUB), .lane(lane), .sat(sat), .y(y_as)
    );

    simd_mul16 #(.DW(DW), .LW(MUL_W)) u_mul (
        .a(op_a), .b(op_b), .hi(op == OP_MULHI), .mac(op == OP_MAC), .sat(sat), .y(y_mul)
    );

    always_comb begin
        bad = (sat == SAT_RSVD);
        case (op)
            OP_ADD, OP_SUB:            res_nx = y_as;
            OP_MULLO, OP_MULHI, OP_MAC: begin
                res_nx = y_mul;
                if (lane != LN_16) bad = 1'b1;
            end
            default: begin
                res_nx = '0;
                bad    = 1'b1;
            end
        endcase
    end

    // next state: CAPTURE on a strobe, RELEASE otherwise
    always_comb begin
        unique case (state)
            S_IDLE:  state_nx = in_valid ? S_DONE : S_IDLE;
            S_DONE:  state_nx = in_valid ? S_DONE : S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            ill_q <= 1'b0;
        end else if (in_valid) begin
            res_q <= bad ? '0 : res_nx;
            ill_q <= bad;
        end
    end

    assign out_valid = (state == S_DONE);
    assign result    = res_q;
    assign illegal   = ill_q;

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> result == '0);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(illegal)));
endmodule

// File: tb/simd_sat_alu_bench.sv
`timescale 1ns/1ps
module simd_sat_alu_bench;
    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  op;
        logic [1:0]  ln;
        logic [1:0]  st;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
        logic        ill;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        // R3 wrap add and subtract
        '{4'd3, 3'd0, 2'd0, 2'd0, 64'h0102_0304_FF80_7F01, 64'h0101_0101_0180_0101, 64'h0203_0405_0000_8002, 1'b0},
        '{4'd3, 3'd0, 2'd1, 2'd0, 64'h0102_0304_FF80_7F01, 64'h0101_0101_0180_0101, 64'h0203_0405_0100_8002, 1'b0},
        '{4'd3, 3'd0, 2'd3, 2'd0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h0000_0001_0000_0000, 1'b0},
        '{4'd3, 3'd0, 2'd2, 2'd0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000, 1'b0},
        '{4'd3, 3'd1, 2'd0, 2'd0, 64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
        '{4'd3, 3'd1, 2'd1, 2'd0, 64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 64'hFEFF_FEFF_FEFF_FEFF, 1'b0},
        // R4 signed clamp
        '{4'd4, 3'd0, 2'd0, 2'd1, 64'h7F80_0140_C000_7F7F, 64'h01FF_0240_C000_807F, 64'h7F80_037F_8000_FF7F, 1'b0},
        '{4'd4, 3'd1, 2'd1, 2'd1, 64'h8000_7FFF_0005_0000, 64'h0001_FFFF_0003_8000, 64'h8000_7FFF_0002_7FFF, 1'b0},
        '{4'd4, 3'd0, 2'd3, 2'd1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0},
        '{4'd4, 3'd0, 2'd2, 2'd1, 64'h7FFF_FFFF_8000_0000, 64'h0000_0001_FFFF_FFFF, 64'h7FFF_FFFF_8000_0000, 1'b0},
        // R5 unsigned clamp
        '{4'd5, 3'd0, 2'd0, 2'd2, 64'hFF01_8080_0000_00F0, 64'h0101_7F81_0000_0010, 64'hFF02_FFFF_0000_00FF, 1'b0},
        '{4'd5, 3'd1, 2'd1, 2'd2, 64'h0005_0003_FFFF_0000, 64'h0003_0005_0001_0001, 64'h0002_0000_FFFE_0000, 1'b0},
        // R6 multiply low / high
        '{4'd6, 3'd2, 2'd1, 2'd0, 64'h0003_FFFF_0100_8000, 64'h0004_FFFF_0100_0002, 64'h000C_0001_0000_0000, 1'b0},
        '{4'd6, 3'd3, 2'd1, 2'd0, 64'h0003_FFFF_0100_8000, 64'h0004_FFFF_0100_0002, 64'h0000_0000_0001_FFFF, 1'b0},
        '{4'd6, 3'd3, 2'd1, 2'd2, 64'h0003_FFFF_0100_8000, 64'h0004_FFFF_0100_0002, 64'h0000_FFFE_0001_0001, 1'b0},
        // R7 pairwise multiply-accumulate
        '{4'd7, 3'd4, 2'd1, 2'd1, 64'h0003_0004_8000_8000, 64'h0005_0006_8000_8000, 64'h0000_0027_7FFF_FFFF, 1'b0},
        '{4'd7, 3'd4, 2'd1, 2'd0, 64'h0003_0004_8000_8000, 64'h0005_0006_8000_8000, 64'h0000_0027_8000_0000, 1'b0},
        '{4'd7, 3'd4, 2'd1, 2'd2, 64'hFFFF_FFFF_0002_FFFF, 64'hFFFF_FFFF_0003_0001, 64'hFFFF_FFFF_0001_0005, 1'b0},
        // R8 unsupported combinations, then a legal one clears the flag
        '{4'd8, 3'd2, 2'd0, 2'd0, 64'h0303_0303_0303_0303, 64'h0202_0202_0202_0202, 64'h0, 1'b1},
        '{4'd8, 3'd5, 2'd0, 2'd0, 64'h0303_0303_0303_0303, 64'h0202_0202_0202_0202, 64'h0, 1'b1},
        '{4'd8, 3'd0, 2'd0, 2'd3, 64'h0303_0303_0303_0303, 64'h0202_0202_0202_0202, 64'h0, 1'b1},
        '{4'd8, 3'd4, 2'd3, 2'd1, 64'h0303_0303_0303_0303, 64'h0202_0202_0202_0202, 64'h0, 1'b1},
        '{4'd8, 3'd0, 2'd0, 2'd0, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic [2:0]  opcode = '0;
    logic [1:0]  lane_sel = '0, sat_mode = '0;
    logic        out_valid, illegal;
    logic [63:0] result;
    int          checks = 0, errors = 0;
    logic        done = 1'b0;

    always #10 clk = ~clk;

    simd_sat_alu u_simd_sat_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .opcode(opcode), .lane_sel(lane_sel), .sat_mode(sat_mode),
        .out_valid(out_valid), .result(result), .illegal(illegal)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] held;
        logic        held_ill;
        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2 out_valid in reset", {63'b0, out_valid}, 64'd0);
        check("R2 result in reset", result, 64'd0);
        check("R2 illegal in reset", {63'b0, illegal}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 out_valid after reset", {63'b0, out_valid}, 64'd0);
        check("R2 result after reset", result, 64'd0);

        for (int i = 0; i < NV; i++) begin
            op_a = VEC[i].a; op_b = VEC[i].b; opcode = VEC[i].op;
            lane_sel = VEC[i].ln; sat_mode = VEC[i].st; in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("R1 out_valid vec %0d", i), {63'b0, out_valid}, 64'd1);
            check($sformatf("R%0d result vec %0d", VEC[i].req, i), result, VEC[i].exp);
            check($sformatf("R%0d illegal vec %0d", VEC[i].req, i), {63'b0, illegal}, {63'b0, VEC[i].ill});
            held = result; held_ill = illegal;
            op_a = ~op_a; opcode = 3'd1;
            @(negedge clk);
            check($sformatf("R1 out_valid low vec %0d", i), {63'b0, out_valid}, 64'd0);
            check($sformatf("R9 result held vec %0d", i), result, held);
            check($sformatf("R9 illegal held vec %0d", i), {63'b0, illegal}, {63'b0, held_ill});
        end

        // R1: back-to-back strobes keep out_valid high, each result in turn
        op_a = 64'h0000_0000_0000_0005; op_b = 64'h0000_0000_0000_0003;
        opcode = 3'd0; lane_sel = 2'd0; sat_mode = 2'd0; in_valid = 1'b1;
        @(negedge clk);
        check("R1 first of pair", result, 64'h0000_0000_0000_0008);
        opcode = 3'd1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 second of pair valid", {63'b0, out_valid}, 64'd1);
        check("R3 second of pair", result, 64'h0000_0000_0000_0002);

        // R2: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R2 result cleared", result, 64'd0);
        check("R2 valid cleared", {63'b0, out_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule